// File: doc/BRIEF.md
# NAND Program/Erase Command Sequencer

This block is the control state machine of a NAND flash device model. It watches command, address and data strobes that an interface front end has already decoded from the shared byte bus. It runs the two-step program and erase sequences, in which a setup command and a later confirm command are both required before anything destructive starts. It drives the ready/busy level, keeps the pass/fail status, and answers the identification command with a fixed byte string.

Internal operation time is modelled by a down-counter loaded from the `busy_len` input when a confirm is accepted. The cell array itself is not modelled. The `op_fail` input is sampled on the final busy cycle and becomes the pass/fail bit of the status byte. A reset command aborts a running operation at once. Write protect blocks every confirm.

Top module: `nand_cmd_seq`

## Requirements
- R1: An erase starts only on a D0h command received after a 60h setup command and exactly three address cycles. The setup and address cycles alone leave `rb_n` high.
- R2: A program starts on a 10h command received after an 80h setup command and at least one data cycle. A 10h after 80h with no data cycle is ignored.
- R3: `rb_n` goes low on the clock edge that accepts a confirm and stays low for exactly `busy_len` cycles, or for one cycle when `busy_len` is 0. It is 1 after reset.
- R4: On the last busy cycle `op_fail` is sampled into status bit 0. A value of 0 means pass.
- R5: After a 70h command, each `rd_strobe` returns the status byte on `rd_data` one cycle later, with `rd_valid` high. Bit 7 is `wp_n`, bit 6 is 1 when ready, bits 5..1 are 0, and bit 0 is the fail bit. With no read mode selected, a read returns 00h.
- R6: An FFh command is accepted at any time. From the next cycle `rb_n` is 1, the sequence returns to idle, the read mode is cleared and the fail bit is 0. An aborted operation never samples `op_fail`.
- R7: A 90h command followed by one address cycle makes successive reads return ECh, 79h, A5h, C0h. The sequence then wraps to ECh.
- R8: Within one erase, the 60h-plus-three-addresses group may be given up to four times before a single D0h. A fifth 60h is ignored and D0h still confirms.
- R9: A D0h or 10h that does not follow its own complete setup is ignored, and the sequencer returns to idle without going busy.
- R10: When `wp_n` is 0, a confirm is refused. `rb_n` stays high, the fail bit is set, and status bit 7 reads 0.
- R11: While busy, only 70h and FFh take effect. Other commands, address cycles and data cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command cycle strobe, byte on `bus_in` |
| addr_we | input | 1 | Address cycle strobe |
| data_we | input | 1 | Serial data cycle strobe |
| rd_strobe | input | 1 | Read cycle request |
| bus_in | input | 8 | Command/address/data byte |
| wp_n | input | 1 | Write protect, 0 = protected |
| op_fail | input | 1 | Operation result, sampled on last busy cycle |
| busy_len | input | CNT_W | Modelled operation time in cycles |
| rb_n | output | 1 | Ready/busy level, 0 = busy (open-drain pull-down) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |

## Verification
The assertions assume that the front end asserts at most one of `cmd_we`, `addr_we` and `data_we` in a cycle. They also assume that `op_fail` and `busy_len` are stable while an operation runs. The bench drives each strobe for one cycle in its own task, one at a time, and changes `op_fail` and `busy_len` only while the sequencer is ready. Read responses are compared in order against an expected-byte queue that fills as reads are issued.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   localparam logic [7:0] OP_ERS_SETUP = 8'h60;
   localparam logic [7:0] OP_ERS_GO    = 8'hD0;
   localparam logic [7:0] OP_PRG_SETUP = 8'h80;
   localparam logic [7:0] OP_PRG_GO    = 8'h10;
   localparam logic [7:0] OP_STATUS    = 8'h70;
   localparam logic [7:0] OP_ABORT     = 8'hFF;
   localparam logic [7:0] OP_IDENT     = 8'h90;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_ERS_ADDR, SQ_ERS_WAIT, SQ_PRG_LOAD, SQ_ID_ADDR
   } seq_state_t;

   typedef enum logic [1:0] {
      RD_NONE, RD_STATUS, RD_IDENT
   } rd_mode_t;

   function automatic logic [7:0] ident_byte(input int unsigned i);
      case (i)
         0:       return 8'hEC;
         1:       return 8'h79;
         2:       return 8'hA5;
         default: return 8'hC0;
      endcase
   endfunction
endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             abort,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   if (CNT_W < 1) begin : g_bad_w
      $error("CNT_W must be at least 1");
   end

   assign done = busy && (cnt == ONE) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (load) begin
         busy <= 1'b1;
         cnt  <= (len == '0) ? ONE : len;
      end else if (busy) begin
         if (cnt == ONE) busy <= 1'b0;
         else            cnt  <= cnt - 1'b1;
      end
   end

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cnt != ONE) && !abort) |=> busy);

   // R6
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);
endmodule

// File: rtl/nand_id_table.sv
module nand_id_table
   import nand_seq_pkg::*;
#(
   parameter int ID_BYTES = 4,
   parameter bit WRAP     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       advance,
   output logic [7:0] byte_o
);
   localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_BYTES - 1);

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] nxt;

   if (ID_BYTES < 1 || ID_BYTES > 4) begin : g_bad_len
      $error("ID_BYTES must be 1 to 4");
   end

   if (WRAP) begin : g_wrap
      assign nxt = (idx == LAST) ? '0 : idx + 1'b1;
   end else begin : g_hold
      assign nxt = (idx == LAST) ? idx : idx + 1'b1;
   end

   assign byte_o = ident_byte(int'(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (start)   idx <= '0;
      else if (advance) idx <= nxt;
   end

   // R7
   id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (byte_o == 8'hEC));
endmodule

// File: rtl/nand_status_bits.sv
module nand_status_bits (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       done,
   input  logic       op_fail,
   input  logic       refuse,
   input  logic       wp_n,
   input  logic       ready,
   output logic [7:0] status_o
);
   logic fail_q;

   assign status_o = {wp_n, ready, 5'b0, fail_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fail_q <= 1'b0;
      else if (clear)  fail_q <= 1'b0;
      else if (done)   fail_q <= op_fail;
      else if (refuse) fail_q <= 1'b1;
   end

   // R4
   fail_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clear) |=> (status_o[0] == $past(op_fail)));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int MAX_PLANES     = 4,
   parameter int ERASE_ADDR_CYC = 3,
   parameter int ID_BYTES       = 4,
   parameter bit ID_WRAP        = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic             addr_we,
   input  logic             data_we,
   input  logic             rd_strobe,
   input  logic [7:0]       bus_in,
   input  logic             wp_n,
   input  logic             op_fail,
   input  logic [CNT_W-1:0] busy_len,
   output logic             rb_n,
   output logic             rd_valid,
   output logic [7:0]       rd_data
);
   localparam int PLANE_W = $clog2(MAX_PLANES + 1);
   localparam int ACYC_W  = $clog2(ERASE_ADDR_CYC + 1);
   localparam logic [PLANE_W-1:0] PLANE_MAX = PLANE_W'(MAX_PLANES);
   localparam logic [ACYC_W-1:0]  ACYC_LAST = ACYC_W'(ERASE_ADDR_CYC - 1);

   if (MAX_PLANES < 1) begin : g_bad_planes
      $error("MAX_PLANES must be at least 1");
   end
   if (ERASE_ADDR_CYC < 1) begin : g_bad_acyc
      $error("ERASE_ADDR_CYC must be at least 1");
   end

   seq_state_t         state;
   rd_mode_t           rmode;
   logic [ACYC_W-1:0]  acnt;
   logic [PLANE_W-1:0] planes;
   logic               prg_data;
   logic               busy, done;
   logic               abort, ers_conf, prg_conf, start_op, refuse;
   logic               id_start, id_adv;
   logic [7:0]         id_byte_w, status_w;

   assign abort    = cmd_we && (bus_in == OP_ABORT);
   assign ers_conf = cmd_we && !busy && (bus_in == OP_ERS_GO) && (state == SQ_ERS_WAIT);
   assign prg_conf = cmd_we && !busy && (bus_in == OP_PRG_GO) && (state == SQ_PRG_LOAD) && prg_data;
   assign start_op = (ers_conf || prg_conf) && wp_n;
   assign refuse   = (ers_conf || prg_conf) && !wp_n;
   assign id_start = addr_we && !busy && (state == SQ_ID_ADDR);
   assign id_adv   = rd_strobe && (rmode == RD_IDENT);
   assign rb_n     = !busy;

   nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(start_op), .abort(abort),
      .len(busy_len), .busy(busy), .done(done)
   );

   nand_id_table #(.ID_BYTES(ID_BYTES), .WRAP(ID_WRAP)) u_ident (
      .clk(clk), .rst_n(rst_n), .start(id_start), .advance(id_adv),
      .byte_o(id_byte_w)
   );

   nand_status_bits u_status (
      .clk(clk), .rst_n(rst_n), .clear(abort), .done(done),
      .op_fail(op_fail), .refuse(refuse), .wp_n(wp_n), .ready(!busy),
      .status_o(status_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         rmode    <= RD_NONE;
         acnt     <= '0;
         planes   <= '0;
         prg_data <= 1'b0;
      end else if (cmd_we) begin
         if (bus_in == OP_ABORT) begin
            state    <= SQ_IDLE;
            rmode    <= RD_NONE;
            acnt     <= '0;
            planes   <= '0;
            prg_data <= 1'b0;
         end else if (bus_in == OP_STATUS) begin
            rmode <= RD_STATUS;
         end else if (!busy) begin
            case (bus_in)
               OP_ERS_SETUP: begin
                  if (state != SQ_ERS_WAIT) begin
                     state  <= SQ_ERS_ADDR;
                     planes <= PLANE_W'(1);
                     acnt   <= '0;
                  end else if (planes < PLANE_MAX) begin
                     state  <= SQ_ERS_ADDR;
                     planes <= planes + 1'b1;
                     acnt   <= '0;
                  end
               end
               OP_PRG_SETUP: begin
                  state    <= SQ_PRG_LOAD;
                  prg_data <= 1'b0;
               end
               OP_IDENT: state <= SQ_ID_ADDR;
               default:  state <= SQ_IDLE;
            endcase
         end
      end else if (addr_we && !busy) begin
         if (state == SQ_ERS_ADDR) begin
            acnt <= acnt + 1'b1;
            if (acnt == ACYC_LAST) state <= SQ_ERS_WAIT;
         end else if (state == SQ_ID_ADDR) begin
            rmode <= RD_IDENT;
            state <= SQ_IDLE;
         end
      end else if (data_we && !busy && (state == SQ_PRG_LOAD)) begin
         prg_data <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_strobe;
         if (rd_strobe) begin
            case (rmode)
               RD_STATUS: rd_data <= status_w;
               RD_IDENT:  rd_data <= id_byte_w;
               default:   rd_data <= 8'h00;
            endcase
         end
      end
   end

   // R3
   rb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rb_n) |-> $past(cmd_we && ((bus_in == OP_ERS_GO) || (bus_in == OP_PRG_GO))));

   // R10
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !wp_n && rb_n) |=> rb_n);

   // R11
   busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rb_n && !abort) |=> (state == SQ_IDLE));

   // R5
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_strobe));

   // R6
   abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> rb_n);
endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cmd_we, addr_we, data_we, rd_strobe;
   logic [7:0]       bus_in;
   logic             wp_n, op_fail;
   logic [CNT_W-1:0] busy_len;
   logic             rb_n, rd_valid;
   logic [7:0]       rd_data;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mon_e;
   string      mon_t;

   always #5 clk = ~clk;

   nand_cmd_seq #(.CNT_W(CNT_W)) u_nand_cmd_seq (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we),
      .data_we(data_we), .rd_strobe(rd_strobe), .bus_in(bus_in),
      .wp_n(wp_n), .op_fail(op_fail), .busy_len(busy_len),
      .rb_n(rb_n), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk); bus_in = b; cmd_we = 1'b1;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic addr(input logic [7:0] b);
      @(negedge clk); bus_in = b; addr_we = 1'b1;
      @(negedge clk); addr_we = 1'b0;
   endtask

   task automatic data(input logic [7:0] b);
      @(negedge clk); bus_in = b; data_we = 1'b1;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] exp, input string tag);
      @(negedge clk); rd_strobe = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   task automatic ers_setup();
      cmd(8'h60); addr(8'h01); addr(8'h02); addr(8'h03);
   endtask

   task automatic busy_chk(input int n, input string tag);
      chk(rb_n == 1'b0, tag, {7'b0, rb_n}, 8'h00);
      repeat (n - 1) @(negedge clk);
      chk(rb_n == 1'b0, tag, {7'b0, rb_n}, 8'h00);
      @(negedge clk);
      chk(rb_n == 1'b1, tag, {7'b0, rb_n}, 8'h01);
   endtask

   task automatic stay_ready(input string tag);
      chk(rb_n == 1'b1, tag, {7'b0, rb_n}, 8'h01);
      @(negedge clk);
      chk(rb_n == 1'b1, tag, {7'b0, rb_n}, 8'h01);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected response", rd_data, 8'h00);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(rd_data == mon_e, mon_t, rd_data, mon_e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=00 expected=01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_we = 1'b0; addr_we = 1'b0; data_we = 1'b0;
      rd_strobe = 1'b0; bus_in = 8'h00; wp_n = 1'b1; op_fail = 1'b0;
      busy_len = CNT_W'(5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state R3, status format R5
      chk(rb_n == 1'b1, "R3 reset ready", {7'b0, rb_n}, 8'h01);
      cmd(8'h70);
      rd(8'hC0, "R5 status after reset");

      // identification R7
      cmd(8'h90); addr(8'h00);
      rd(8'hEC, "R7 id byte 0"); rd(8'h79, "R7 id byte 1");
      rd(8'hA5, "R7 id byte 2"); rd(8'hC0, "R7 id byte 3");
      rd(8'hEC, "R7 id wrap");

      // erase pass R1 R3 R4
      ers_setup();
      stay_ready("R1 setup alone stays ready");
      cmd(8'hD0);
      busy_chk(5, "R3 erase busy window");
      cmd(8'h70);
      rd(8'hC0, "R4 erase pass status");

      // erase fail R4
      op_fail = 1'b1;
      ers_setup(); cmd(8'hD0);
      busy_chk(5, "R1 erase fail busy");
      op_fail = 1'b0;
      cmd(8'h70);
      rd(8'hC1, "R4 erase fail status");

      // program with commands during busy R2 R5 R11
      busy_len = CNT_W'(20);
      cmd(8'h80); addr(8'h10); data(8'hAA); data(8'h55);
      cmd(8'h10);
      chk(rb_n == 1'b0, "R2 program starts", {7'b0, rb_n}, 8'h00);
      cmd(8'h70);
      rd(8'h81, "R5 status while busy");
      cmd(8'h90); addr(8'h00);
      rd(8'h81, "R11 ident ignored while busy");
      while (!rb_n) @(negedge clk);
      rd(8'hC0, "R4 program pass status");

      // program without data R2
      busy_len = CNT_W'(5);
      cmd(8'h80); addr(8'h20); cmd(8'h10);
      stay_ready("R2 no data no program");

      // orphan confirms R9
      cmd(8'hD0);
      stay_ready("R9 lone D0 ignored");
      cmd(8'h10);
      stay_ready("R9 lone 10 ignored");
      cmd(8'h60); addr(8'h01); addr(8'h02); cmd(8'hD0);
      stay_ready("R9 short erase address ignored");

      // multi-plane R8 (ends in fail to set the fail bit)
      op_fail = 1'b1;
      for (int p = 0; p < 4; p++) ers_setup();
      cmd(8'h60);
      cmd(8'hD0);
      busy_chk(5, "R8 fifth setup ignored, D0 confirms");

      // abort during busy R6
      busy_len = CNT_W'(20);
      ers_setup(); cmd(8'hD0);
      chk(rb_n == 1'b0, "R6 busy before abort", {7'b0, rb_n}, 8'h00);
      cmd(8'hFF);
      chk(rb_n == 1'b1, "R6 ready after abort", {7'b0, rb_n}, 8'h01);
      repeat (25) @(negedge clk);
      cmd(8'h70);
      rd(8'hC0, "R6 fail cleared, no late sample");
      op_fail = 1'b0;

      // short busy windows R3
      busy_len = CNT_W'(1);
      ers_setup(); cmd(8'hD0);
      busy_chk(1, "R3 one-cycle busy");
      busy_len = CNT_W'(0);
      ers_setup(); cmd(8'hD0);
      busy_chk(1, "R3 zero length as one");

      // write protect R10
      busy_len = CNT_W'(5);
      wp_n = 1'b0;
      ers_setup(); cmd(8'hD0);
      stay_ready("R10 confirm refused");
      cmd(8'h70);
      rd(8'h41, "R10 refused status");
      cmd(8'hFF); cmd(8'h70);
      rd(8'h40, "R10 abort status under protect");
      wp_n = 1'b1;

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all responses seen", 8'(exp_q.size()), 8'h00);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule